// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block moves 8-bit words over a three-wire synchronous link: a transmit data line, a receive data line and a shift-clock pin that is either driven by the port or fed from outside. In clock-output mode the port is the link master. It divides the system clock to make the shift clock, and it runs one burst of 8 clock pulses either when a word is written for transmission or when reception is enabled and the previous received word has been consumed. In clock-input mode the port is a slave. It shifts on the active edge of an external clock, and that edge is chosen by a polarity select.

Words travel least significant bit first. Received bits build up in a first-stage shift register and are copied as a whole word into a holding register that the host reads. The end of a transmission and the end of a reception each set a sticky flag that serves as an interrupt request. The host clears the flags with explicit strobes. A read of the holding register also clears the receive flag. A write to the transmit buffer is ignored while the port is busy.

Top module: `sio_port`

## Requirements
- R1: In clock-output mode (`out_mode`=1, `sclk_oe`=1), an accepted `tx_wr` produces exactly 8 low-going pulses on `sclk_out`, which otherwise rests high. `txd` changes on each falling edge and carries bit 0 first, up to bit 7, so that it is valid at each rising edge. `txd` rests at 1 whenever `tx_busy` is 0.
- R2: In clock-output mode, `rxd` is sampled on each rising edge of `sclk_out` during a burst that was armed for reception. The first sample is bit 0. After the 8th sample the whole word appears on `rx_data` and `rx_flag` is set in the same cycle. `rx_data` changes at no other time.
- R3: In clock-output mode, `tx_flag` becomes 1 exactly 16*DIV_HALF clock cycles after the edge that accepts `tx_wr`. It is still 0 one cycle before that.
- R4: In clock-input mode, `tx_wr` only loads the word. `txd` shows bit 0 at once and `tx_busy` rises. Without active external edges, nothing more happens: `txd` holds bit 0 and no flag is set. Each later active edge advances `txd` by one bit, and the 8th active edge ends the word and sets `tx_flag`.
- R5: `edge_sel`=0 makes the rising edge of `sclk_in` active and `edge_sel`=1 makes the falling edge active. The opposite edge shifts nothing.
- R6: In clock-input mode with `rx_en`=1, `rxd` is sampled on every active edge. After 8 samples the word is loaded into `rx_data` with the first sample as bit 0, and `rx_flag` is set. With `rx_en`=0 nothing is received.
- R7: In clock-output mode, holding `rx_en` at 1 while `rx_flag` is 0 starts a receive burst. No further burst starts while `rx_flag` is 1. Pulsing `rx_rd` clears the flag, and the next burst then starts by itself.
- R8: Both flags are sticky. `clr_tx` clears `tx_flag`, and `clr_rx` or `rx_rd` clears `rx_flag`. When a set and a clear fall in the same cycle, the flag ends up set.
- R9: `tx_busy` is 1 while a word is being shifted and, in clock-output mode, while any burst runs. A `tx_wr` during that time is ignored: the word on the wire and the number of clock pulses are unchanged, and no second transfer follows.
- R10: After reset, `txd`=1, `sclk_out`=1, `tx_flag`=0, `rx_flag`=0, `tx_busy`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_mode | input | 1 | 1: port drives the shift clock; 0: external shift clock |
| edge_sel | input | 1 | Active external edge: 0 rising, 1 falling |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit word |
| tx_wdata | input | DATA_W | Transmit word |
| rx_rd | input | 1 | Read strobe for the holding register (clears `rx_flag`) |
| clr_tx | input | 1 | Clear strobe for `tx_flag` |
| clr_rx | input | 1 | Clear strobe for `rx_flag` |
| rx_data | output | DATA_W | Receive holding register |
| tx_flag | output | 1 | Transmit-complete request |
| rx_flag | output | 1 | Receive-complete request |
| tx_busy | output | 1 | Transfer in progress; writes are ignored |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Enable for the shift-clock pin driver |

## Verification
In clock-output mode every result lands on a fixed cycle: `tx_flag`, `rx_flag` and `rx_data` update on edge 16*DIV_HALF after the accepting edge. The bench counts negative edges from that write, checks the flag low one cycle early and high on the due cycle, and times a clear strobe into the setting cycle. In clock-input mode the external edge passes through the synchroniser before it acts, so the bench samples `txd` only midway between its own external edges. It reads the flags only several system cycles after the last active edge. Output-mode serial data is captured by a monitor on `sclk_out`, using the value `txd` held before the rising edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Active edge of the external shift clock
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/sio_clkgen.sv
// Shift-clock generator for clock-output mode: one burst of DATA_W pulses,
// idle high, half period DIV_HALF system cycles.
module sio_clkgen #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic sclk,
  output logic fall_ev,
  output logic rise_ev,
  output logic last_rise
);
  localparam int HC_W  = $clog2(DIV_HALF + 1);
  localparam int CNT_W = $clog2(DATA_W);

  logic [HC_W-1:0]  hc;
  logic [CNT_W-1:0] nrise;
  logic             tick;

  assign tick      = active && (hc == HC_W'(DIV_HALF - 1));
  assign fall_ev   = tick && sclk;
  assign rise_ev   = tick && !sclk;
  assign last_rise = rise_ev && (nrise == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hc     <= '0;
      sclk   <= 1'b1;
      nrise  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        hc     <= '0;
        nrise  <= '0;
      end
    end else if (tick) begin
      hc   <= '0;
      sclk <= ~sclk;
      if (!sclk) begin
        nrise <= nrise + 1'b1;
        if (last_rise) active <= 1'b0;
      end
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/sio_sync_edge.sv
// Synchroniser for the external clock and receive data, plus active-edge detect.
module sio_sync_edge #(
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_in,
  input  logic            rxd,
  input  sio_pkg::edge_e  edge_sel,
  output logic            ext_edge,
  output logic            rxd_s
);
  logic [SYNC_N:0]   ck_q;
  logic [SYNC_N-1:0] d_q;
  logic              cur, prev;

  assign cur   = ck_q[SYNC_N-1];
  assign prev  = ck_q[SYNC_N];
  assign rxd_s = d_q[SYNC_N-1];

  always_comb begin
    if (edge_sel == sio_pkg::EDGE_FALL) ext_edge = prev && !cur;
    else                                ext_edge = !prev && cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= '0;
      d_q  <= '0;
    end else begin
      ck_q <= {ck_q[SYNC_N-1:0], sclk_in};
      d_q  <= {d_q[SYNC_N-2:0], rxd};
    end
  end
endmodule

// File: rtl/sio_tx.sv
// Transmit shifter: LSB first, clocked by internal falling edges or external active edges.
module sio_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_mode,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              fall_ev,
  input  logic              last_rise,
  input  logic              ext_edge,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              last_ext;

  assign last_ext = ext_edge && (cnt == CNT_W'(DATA_W - 1));
  assign done     = busy && (out_mode ? last_rise : last_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (out_mode) begin
        sreg <= data;
      end else begin
        txd  <= data[0];
        sreg <= data >> 1;
      end
    end else if (done) begin
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (busy && out_mode && fall_ev) begin
      txd  <= sreg[0];
      sreg <= sreg >> 1;
    end else if (busy && !out_mode && ext_edge) begin
      txd  <= sreg[0];
      sreg <= sreg >> 1;
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sio_rx.sv
// Receive shifter and holding register.
module sio_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_mode,
  input  logic              rx_en,
  input  logic              flag,
  input  logic              start_acc,
  input  logic              rise_ev,
  input  logic              last_rise,
  input  logic              ext_edge,
  input  logic              rxd_raw,
  input  logic              rxd_sync,
  output logic [DATA_W-1:0] hold,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-2:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic [DATA_W-1:0] nxt_o, nxt_i;
  logic              out_shift, in_shift, in_last, out_last;

  assign nxt_o     = {rxd_raw, sreg};
  assign nxt_i     = {rxd_sync, sreg};
  assign out_shift = out_mode && armed && rise_ev;
  assign out_last  = out_shift && last_rise;
  assign in_shift  = !out_mode && rx_en && ext_edge;
  assign in_last   = in_shift && (cnt == CNT_W'(DATA_W - 1));
  assign done      = out_last || in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      cnt   <= '0;
      armed <= 1'b0;
      hold  <= '0;
    end else begin
      if (start_acc)     armed <= rx_en && !flag;
      else if (out_last) armed <= 1'b0;

      if (!out_mode && !rx_en) cnt <= '0;
      else if (in_last)        cnt <= '0;
      else if (in_shift)       cnt <= cnt + 1'b1;

      if (out_shift)     sreg <= nxt_o[DATA_W-1:1];
      else if (in_shift) sreg <= nxt_i[DATA_W-1:1];

      if (out_last)     hold <= nxt_o;
      else if (in_last) hold <= nxt_i;
    end
  end
endmodule

// File: rtl/sio_port.sv
// Synchronous serial port top: clock source select, engines and sticky flags.
module sio_port #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_mode,
  input  logic              edge_sel,
  input  logic              rx_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              clr_tx,
  input  logic              clr_rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_flag,
  output logic              rx_flag,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe
);
  logic cg_active, cg_sclk, fall_ev, rise_ev, last_rise;
  logic ext_edge, rxd_s;
  logic tx_busy_eng, tx_done, rx_done;
  logic tx_flag_q, rx_flag_q;
  logic busy_all, tx_acc, rx_go, cg_start, start_acc;
  sio_pkg::edge_e edge_q;

  assign edge_q    = sio_pkg::edge_e'(edge_sel);
  assign busy_all  = tx_busy_eng || (out_mode && cg_active);
  assign tx_acc    = tx_wr && !busy_all;
  assign rx_go     = out_mode && rx_en && !rx_flag_q;
  assign cg_start  = out_mode && (tx_acc || rx_go);
  assign start_acc = cg_start && !cg_active;

  sio_clkgen #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_clkgen (
    .clk(clk), .rst(rst), .start(cg_start), .active(cg_active), .sclk(cg_sclk),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .last_rise(last_rise)
  );

  sio_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .rxd(rxd), .edge_sel(edge_q),
    .ext_edge(ext_edge), .rxd_s(rxd_s)
  );

  sio_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .out_mode(out_mode), .load(tx_acc), .data(tx_wdata),
    .fall_ev(fall_ev), .last_rise(last_rise), .ext_edge(ext_edge),
    .txd(txd), .busy(tx_busy_eng), .done(tx_done)
  );

  sio_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .out_mode(out_mode), .rx_en(rx_en), .flag(rx_flag_q),
    .start_acc(start_acc), .rise_ev(rise_ev), .last_rise(last_rise),
    .ext_edge(ext_edge), .rxd_raw(rxd), .rxd_sync(rxd_s),
    .hold(rx_data), .done(rx_done)
  );

  // Sticky flags: set has priority over clear
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
    end else begin
      if (tx_done)     tx_flag_q <= 1'b1;
      else if (clr_tx) tx_flag_q <= 1'b0;
      if (rx_done)               rx_flag_q <= 1'b1;
      else if (clr_rx || rx_rd)  rx_flag_q <= 1'b0;
    end
  end

  assign tx_flag  = tx_flag_q;
  assign rx_flag  = rx_flag_q;
  assign tx_busy  = busy_all;
  assign sclk_out = cg_sclk;
  assign sclk_oe  = out_mode;
endmodule

// File: rtl/sio_port_chk.sv
// Property checker attached to sio_port.
module sio_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_wr,
  input logic              clr_tx,
  input logic              clr_rx,
  input logic              rx_rd,
  input logic              tx_flag,
  input logic              rx_flag,
  input logic              tx_busy,
  input logic              txd,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic [DATA_W-1:0] rx_data
);
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && !tx_busy) |-> sclk_out);

  p_txd_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  p_rxdata_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_flag);

  p_txflag_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_flag) |-> $past(tx_busy));

  p_no_rx_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && rx_flag && !tx_busy && !tx_wr) |=> !tx_busy);

  p_txflag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_flag && !clr_tx) |=> tx_flag);

  p_rxflag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !clr_rx && !rx_rd) |=> rx_flag);
endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_wr(tx_wr), .clr_tx(clr_tx), .clr_rx(clr_rx),
  .rx_rd(rx_rd), .tx_flag(tx_flag), .rx_flag(rx_flag), .tx_busy(tx_busy),
  .txd(txd), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_data(rx_data)
);

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
  localparam int DW = 8;
  localparam int H  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic out_mode = 0, edge_sel = 0, rx_en = 0, tx_wr = 0;
  logic rx_rd = 0, clr_tx = 0, clr_rx = 0, sclk_in = 0;
  logic [DW-1:0] tx_wdata = '0;
  logic rxd_m = 1'b1, rxd_t = 1'b1;
  wire  rxd = out_mode ? rxd_m : rxd_t;
  wire [DW-1:0] rx_data;
  wire tx_flag, rx_flag, tx_busy, txd, sclk_out, sclk_oe;

  int n_chk = 0;
  int n_fail = 0;

  sio_port #(.DATA_W(DW), .DIV_HALF(H), .SYNC_N(2)) dut_i (
    .clk(clk), .rst(rst), .out_mode(out_mode), .edge_sel(edge_sel), .rx_en(rx_en),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .clr_tx(clr_tx), .clr_rx(clr_rx),
    .rx_data(rx_data), .tx_flag(tx_flag), .rx_flag(rx_flag), .tx_busy(tx_busy),
    .txd(txd), .rxd(rxd), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  // Slave model for clock-output mode
  logic [DW-1:0] mon_cap = '0;
  logic [DW-1:0] mon_pat = '0;
  int  mon_pulses = 0;
  int  mon_idx = 0;
  logic txd_n = 1'b1;
  always @(negedge clk) txd_n = txd;
  always @(posedge sclk_out) begin
    mon_cap = {txd_n, mon_cap[DW-1:1]};
    mon_pulses++;
  end
  always @(negedge sclk_out) begin
    rxd_m = mon_pat[mon_idx % DW];
    mon_idx++;
  end

  // Vector table: {out_mode, edge_sel, tx word, rx word}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'h01, 8'h80},
    {1'b0, 1'b0, 8'hC6, 8'h5B},
    {1'b0, 1'b0, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h72, 8'hE1},
    {1'b0, 1'b1, 8'h0F, 8'h96}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && tx_busy; i++) @(negedge clk);
  endtask

  task automatic wait_rxflag();
    for (int i = 0; i < 4000 && !rx_flag; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_tx = 1; rx_rd = 1; tick(1); clr_tx = 0; rx_rd = 0;
  endtask

  task automatic mon_reset(input logic [DW-1:0] pat);
    mon_pat = pat; mon_idx = 0; mon_pulses = 0; mon_cap = '0;
  endtask

  task automatic out_vec(input logic [DW-1:0] tx, input logic [DW-1:0] rx);
    out_mode = 1; mon_reset(rx); tick(2);
    tx_wdata = tx; tx_wr = 1; rx_en = 1; tick(1); tx_wr = 0; rx_en = 0;
    wait_idle(); tick(1);
    chk("R1 out-mode txd word", mon_cap, tx);
    chk("R1 pulse count", mon_pulses, 8);
    chk("R2 out-mode rx word", rx_data, rx);
    chk("R2 rx_flag", rx_flag, 1);
    chk("R3 tx_flag", tx_flag, 1);
    clear_all();
    chk("R8 flags cleared", {tx_flag, rx_flag}, 0);
  endtask

  // Master clocking in clock-input mode: 8 active edges
  task automatic in_clock(input logic edg, input logic [DW-1:0] rx, output logic [DW-1:0] cap);
    cap = '0;
    for (int k = 0; k < DW; k++) begin
      rxd_t = rx[k]; tick(4);
      cap = {txd, cap[DW-1:1]};
      sclk_in = ~edg; tick(8);
      sclk_in = edg;  tick(4);
    end
  endtask

  task automatic in_vec(input logic edg, input logic [DW-1:0] tx, input logic [DW-1:0] rx);
    logic [DW-1:0] cap;
    out_mode = 0; edge_sel = edg; sclk_in = edg; tick(6);
    rx_en = 1; tx_wdata = tx; tx_wr = 1; tick(1); tx_wr = 0; tick(3);
    in_clock(edg, rx, cap); tick(6);
    chk(edg ? "R5 falling-edge txd word" : "R4 rising-edge txd word", cap, tx);
    chk("R6 in-mode rx word", rx_data, rx);
    chk("R6 rx_flag", rx_flag, 1);
    chk("R4 tx_flag after 8 edges", tx_flag, 1);
    chk("R4 busy cleared", tx_busy, 0);
    rx_en = 0; clear_all();
  endtask

  initial begin
    logic [DW-1:0] cap;
    tick(3);
    rst = 0;
    tick(1);
    // R10 reset state
    chk("R10 txd", txd, 1);
    chk("R10 sclk_out", sclk_out, 1);
    chk("R10 flags", {tx_flag, rx_flag}, 0);
    chk("R10 busy", tx_busy, 0);
    chk("R10 rx_data", rx_data, 0);

    for (int i = 0; i < 6; i++) begin
      if (VEC[i][17]) out_vec(VEC[i][15:8], VEC[i][7:0]);
      else            in_vec(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R3 exact timing, R8 set wins over a clear in the same cycle
    out_mode = 1; mon_reset(8'h00); tick(2);
    tx_wdata = 8'h96; tx_wr = 1; tick(1); tx_wr = 0;
    tick(16*H - 1);
    chk("R3 tx_flag one cycle early", tx_flag, 0);
    clr_tx = 1; tick(1); clr_tx = 0;
    chk("R8 set wins over clear", tx_flag, 1);
    chk("R3 busy dropped", tx_busy, 0);
    clr_tx = 1; tick(1); clr_tx = 0;
    chk("R8 clr_tx clears", tx_flag, 0);

    // R9 write while busy ignored
    mon_reset(8'h00); tick(2);
    tx_wdata = 8'hC3; tx_wr = 1; tick(1); tx_wr = 0; tick(3);
    chk("R9 busy during shift", tx_busy, 1);
    tx_wdata = 8'hFF; tx_wr = 1; tick(1); tx_wr = 0;
    wait_idle(); tick(1);
    chk("R9 word unchanged", mon_cap, 8'hC3);
    clear_all(); tick(40);
    chk("R9 no second transfer pulses", mon_pulses, 8);
    chk("R9 no second flag", tx_flag, 0);

    // R4 input mode: no shifting without edges
    out_mode = 0; edge_sel = 0; sclk_in = 0; tick(6);
    tx_wdata = 8'h5A; tx_wr = 1; tick(1); tx_wr = 0; tick(40);
    chk("R4 txd holds bit0", txd, 0);
    chk("R4 busy held", tx_busy, 1);
    chk("R4 no flag without edges", tx_flag, 0);
    in_clock(1'b0, 8'hFF, cap); tick(6);
    chk("R4 word after edges", cap, 8'h5A);
    chk("R6 rx disabled gives no flag", rx_flag, 0);
    clear_all();

    // R7 clock-output reception flow
    out_mode = 1; mon_reset(8'h4D); tick(2);
    rx_en = 1;
    wait_rxflag(); tick(1);
    chk("R7 first rx word", rx_data, 8'h4D);
    chk("R7 first burst pulses", mon_pulses, 8);
    tick(40);
    chk("R7 no burst while flag set", mon_pulses, 8);
    mon_pat = 8'hB2;
    rx_rd = 1; tick(1); rx_rd = 0;
    chk("R8 rx_rd clears rx_flag", rx_flag, 0);
    wait_rxflag(); tick(1);
    chk("R7 second rx word", rx_data, 8'hB2);
    chk("R7 second burst pulses", mon_pulses, 16);
    rx_en = 0; tick(1);
    clr_rx = 1; tick(1); clr_rx = 0;
    chk("R8 clr_rx clears", rx_flag, 0);
    tick(40);
    chk("R7 stopped after disable", mon_pulses, 16);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule